// File: doc/BRIEF.md
# Three-Level Virtual Memory Page-Table Walker

This block translates a 39-bit virtual address into a 56-bit physical address by walking a three-level radix page table held in memory. A requester hands over one address together with its access kind (instruction fetch, load or store) and the privilege context (user or supervisor, the supervisor-may-touch-user flag and the make-executable-readable flag). It also supplies the physical page number of the root table. The walker then reads 8-byte table entries one at a time over a simple memory request/response port. It finishes with either a physical address or a page fault, and it presents that outcome on a result port until the consumer takes it.

Walks start at the top level (level 2) and go down one level per non-leaf entry. A leaf entry may sit at level 1 (2 MiB page) or level 2 (1 GiB page). Such a large page must be naturally aligned, or the walk faults. When the leaf is usable but its accessed flag is clear, the walker writes the entry back before it answers. It does the same when the access is a store and the dirty flag is clear. The write goes through the same memory port. Only one walk is in flight at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.
- R2: The first entry read goes to root_ppn·4096 + VA[38:30]·8. In general, a level-i read goes to base + VA[20+9i:12+9i]·8. Every table read has `mem_req_we`=0 and an address that is a multiple of 8.
- R3: After a non-leaf entry (V=bit0 set, R=bit1 and X=bit3 both clear), the next base is the entry's PPN field (bits 53:10) times 4096, and the level drops by one.
- R4: An entry with V clear ends the walk with `res_fault`=1. The cause is 12 for fetch, 13 for load and 15 for store, where `req_type` is 0=fetch, 1=load, 2=store.
- R5: A non-leaf entry found at level 0 faults with the cause from R4.
- R6: A leaf faults in these cases: user mode (`req_user`=1) without U (bit4); supervisor mode with U set when `req_sum`=0 or the access is a fetch; a fetch without X; a load without R, unless `req_mxr`=1 and X is set; a store without W (bit2).
- R7: A leaf at level 1 or 2 whose PPN has any nonzero bit among its low 9·level bits faults.
- R8: A successful result has PA = PPN·4096 with bits [12+9·level−1:12] replaced by the same VA bits. PA[11:0] equals VA[11:0].
- R9: A permitted leaf with A (bit6) clear, or a store with D (bit7) clear, causes one write with `mem_req_we`=1. The write goes to the leaf's address with data = entry | A | (store ? D : 0) and comes before the result. A faulting walk issues no write.
- R10: `req_ready` is 0 from acceptance until the result is taken. While `res_valid`=1 and `res_ready`=0, the result fields hold steady.
- R11: While `mem_req_valid`=1 and `mem_req_ready`=0, the address, write flag and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 39 | Virtual address |
| req_type | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | Access made from user mode |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| root_ppn | input | 44 | Physical page number of the root table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write entry, 0 = read entry |
| mem_req_addr | output | 56 | Entry physical address |
| mem_req_wdata | output | 64 | Entry value for a write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Walk ended in a page fault |
| res_cause | output | 4 | Fault cause code |
| res_pa | output | 56 | Physical address, zero on fault |

## Verification
A permission check and the accessed/dirty update come due on the same leaf in the same response cycle. The fault must win, and no write may follow. The bench provokes this with a store to a readable, non-writable leaf whose accessed flag is clear. It confirms that the reference model expects no memory write and that the design issues none before the fault result. A second collision comes from handshake stalls: the memory and result ready signals are driven from a pseudo-random sequence, so a stalled request and a pending response line up on the port. The request must hold steady through the stall, and that is compared on every clock.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 39;
    localparam int PA_W   = 56;
    localparam int PPN_W  = 44;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = 9;
    localparam int LEVELS = 3;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int PTE_W  = 64;
    localparam int PTE_SZ_SH = 3;
    localparam int CAUSE_W = 4;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;
    localparam int PPN_LSB = 10;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PF = 4'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 4'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        walk_state_e          st;
        logic [LVL_W-1:0]     lvl;
        logic [VA_W-1:0]      va;
        logic [1:0]           acc;
        logic                 usr;
        logic                 sum;
        logic                 mxr;
        logic [PA_W-1:0]      base;
        logic [PA_W-1:0]      ent_addr;
        logic [PTE_W-1:0]     wdata;
        logic                 fault;
        logic [CAUSE_W-1:0]   cause;
        logic [PA_W-1:0]      pa;
    } walk_regs_t;

    function automatic logic [CAUSE_W-1:0] fault_cause(input logic [1:0] acc);
        case (acc)
            ACC_FETCH: fault_cause = CAUSE_FETCH_PF;
            ACC_LOAD:  fault_cause = CAUSE_LOAD_PF;
            default:   fault_cause = CAUSE_STORE_PF;
        endcase
    endfunction
endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [7:0] flags,
    input  logic [1:0] acc,
    input  logic       usr,
    input  logic       sum,
    input  logic       mxr,
    output logic       allow
);
    logic is_fetch;
    logic mode_ok;
    logic kind_ok;

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        if (usr) begin
            mode_ok = flags[B_U];
        end else begin
            mode_ok = !(flags[B_U] && (!sum || is_fetch));
        end
        case (acc)
            ACC_FETCH: kind_ok = flags[B_X];
            ACC_LOAD:  kind_ok = flags[B_R] || (mxr && flags[B_X]);
            default:   kind_ok = flags[B_W];
        endcase
        allow = flags[B_V] && mode_ok && kind_ok;
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  ent_addr
);
    logic [VPN_W-1:0] vpn_lv [LEVELS];
    logic [VPN_W-1:0] vpn_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
        assign vpn_lv[g] = va[OFF_W + VPN_W*g +: VPN_W];
    end

    always_comb begin
        vpn_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) vpn_sel = vpn_lv[i];
        end
        ent_addr = base + {{(PA_W-VPN_W-PTE_SZ_SH){1'b0}}, vpn_sel, {PTE_SZ_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] ppn,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic             misaligned,
    output logic [PA_W-1:0]  pa
);
    logic [PPN_W-1:0] va_vpn;
    logic [PA_W-1:0]  pa_lv  [LEVELS];
    logic             mis_lv [LEVELS];

    assign va_vpn = PPN_W'(va[VA_W-1:OFF_W]);

    for (genvar g = 0; g < LEVELS; g++) begin : g_page
        localparam logic [PPN_W-1:0] LOMASK = PPN_W'((64'd1 << (VPN_W*g)) - 64'd1);
        assign mis_lv[g] = |(ppn & LOMASK);
        assign pa_lv[g]  = {(ppn & ~LOMASK) | (va_vpn & LOMASK), va[OFF_W-1:0]};
    end

    always_comb begin
        misaligned = 1'b0;
        pa         = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) begin
                misaligned = mis_lv[i];
                pa         = pa_lv[i];
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [38:0]       req_va,
    input  logic [1:0]        req_type,
    input  logic              req_user,
    input  logic              req_sum,
    input  logic              req_mxr,
    input  logic [43:0]       root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [55:0]       mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [3:0]        res_cause,
    output logic [55:0]       res_pa
);
    walk_regs_t r_d, r_q;

    logic [PA_W-1:0]  rd_addr;
    logic [PPN_W-1:0] rsp_ppn;
    logic             leaf_allow;
    logic             leaf_mis;
    logic [PA_W-1:0]  leaf_pa;
    logic             rsp_is_leaf;
    logic             ad_needed;
    logic [PTE_W-1:0] ad_value;

    assign rsp_ppn     = mem_rsp_data[PPN_LSB +: PPN_W];
    assign rsp_is_leaf = mem_rsp_data[B_R] || mem_rsp_data[B_X];

    ptw_entry_addr u_addr (
        .base     (r_q.base),
        .va       (r_q.va),
        .lvl      (r_q.lvl),
        .ent_addr (rd_addr)
    );

    ptw_perm_check u_perm (
        .flags (mem_rsp_data[7:0]),
        .acc   (r_q.acc),
        .usr   (r_q.usr),
        .sum   (r_q.sum),
        .mxr   (r_q.mxr),
        .allow (leaf_allow)
    );

    ptw_leaf_pa u_leaf (
        .ppn        (rsp_ppn),
        .va         (r_q.va),
        .lvl        (r_q.lvl),
        .misaligned (leaf_mis),
        .pa         (leaf_pa)
    );

    always_comb begin
        ad_needed = !mem_rsp_data[B_A] || ((r_q.acc == ACC_STORE) && !mem_rsp_data[B_D]);
        ad_value  = mem_rsp_data;
        ad_value[B_A] = 1'b1;
        if (r_q.acc == ACC_STORE) ad_value[B_D] = 1'b1;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_RD_REQ;
                    r_d.lvl   = LVL_W'(LEVELS - 1);
                    r_d.va    = req_va;
                    r_d.acc   = req_type;
                    r_d.usr   = req_user;
                    r_d.sum   = req_sum;
                    r_d.mxr   = req_mxr;
                    r_d.base  = {root_ppn, {OFF_W{1'b0}}};
                    r_d.fault = 1'b0;
                    r_d.cause = '0;
                    r_d.pa    = '0;
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) begin
                    r_d.st       = ST_RD_WAIT;
                    r_d.ent_addr = rd_addr;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[B_V]) begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b1;
                        r_d.cause = fault_cause(r_q.acc);
                    end else if (rsp_is_leaf) begin
                        if (!leaf_allow || leaf_mis) begin
                            r_d.st    = ST_DONE;
                            r_d.fault = 1'b1;
                            r_d.cause = fault_cause(r_q.acc);
                        end else begin
                            r_d.pa = leaf_pa;
                            if (ad_needed) begin
                                r_d.st    = ST_WR_REQ;
                                r_d.wdata = ad_value;
                            end else begin
                                r_d.st = ST_DONE;
                            end
                        end
                    end else if (r_q.lvl == '0) begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b1;
                        r_d.cause = fault_cause(r_q.acc);
                    end else begin
                        r_d.st   = ST_RD_REQ;
                        r_d.lvl  = r_q.lvl - 1'b1;
                        r_d.base = {rsp_ppn, {OFF_W{1'b0}}};
                    end
                end
            end
            ST_WR_REQ: begin
                if (mem_req_ready) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                if (res_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_RD_REQ) || (r_q.st == ST_WR_REQ);
    assign mem_req_we    = (r_q.st == ST_WR_REQ);
    assign mem_req_addr  = (r_q.st == ST_WR_REQ) ? r_q.ent_addr : rd_addr;
    assign mem_req_wdata = r_q.wdata;
    assign res_valid     = (r_q.st == ST_DONE);
    assign res_fault     = r_q.fault;
    assign res_cause     = r_q.cause;
    assign res_pa        = r_q.pa;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [38:0] req_va,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [55:0] mem_req_addr,
    input logic [63:0] mem_req_wdata,
    input logic        res_valid,
    input logic        res_ready,
    input logic        res_fault,
    input logic [3:0]  res_cause,
    input logic [55:0] res_pa
);
    logic [11:0] off_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_cap <= '0;
        else if (req_valid && req_ready) off_cap <= req_va[11:0];
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid));

    p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa)
                                       && $stable(res_fault) && $stable(res_cause)));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                               && $stable(mem_req_we) && $stable(mem_req_wdata)));

    p_entry_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    p_cause_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_cause == 4'd12 || res_cause == 4'd13 || res_cause == 4'd15));

    p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_pa[11:0] == off_cap));
endmodule

bind pt_walker ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_fault     (res_fault),
    .res_cause     (res_cause),
    .res_pa        (res_pa)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [43:0] ROOT = 44'h80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_va = '0;
    logic [1:0]  req_type = '0;
    logic        req_user = 1'b0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_fault;
    logic [3:0]  res_cause;
    logic [55:0] res_pa;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_type(req_type), .req_user(req_user), .req_sum(req_sum),
        .req_mxr(req_mxr), .root_ppn(ROOT),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_ready(res_ready), .res_fault(res_fault),
        .res_cause(res_cause), .res_pa(res_pa)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit stall_en = 1'b0;

    logic [63:0] mem [logic [55:0]];
    logic [55:0] q_addr [$];
    logic        q_we   [$];
    logic [63:0] q_data [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit next_ready();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return stall_en ? lfsr[0] : 1'b1;
    endfunction

    function automatic logic [63:0] rd(input logic [55:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [9:0] fl);
        return {10'd0, ppn, fl};
    endfunction

    function automatic logic [38:0] mkva(input int v2, input int v1, input int v0, input int off);
        return {v2[8:0], v1[8:0], v0[8:0], off[11:0]};
    endfunction

    // Reference walk: fills the expected memory-operation queues and the outcome.
    task automatic model(input logic [38:0] va, input logic [1:0] acc, input bit usr,
                         input bit sum, input bit mxr, output bit f,
                         output logic [3:0] c, output logic [55:0] pa);
        longint unsigned base = longint'(ROOT) * 4096;
        int lvl = 2;
        logic [63:0] e;
        logic [55:0] a;
        bit ok;
        f = 0; pa = '0;
        c = (acc == 0) ? 4'd12 : (acc == 1) ? 4'd13 : 4'd15;
        forever begin
            a = 56'(base + ((longint'(va) >> (12 + 9*lvl)) & 'h1FF) * 8);
            q_addr.push_back(a); q_we.push_back(0); q_data.push_back('0);
            e = rd(a);
            if (!e[0]) begin f = 1; break; end
            if (e[1] || e[3]) begin
                ok = 1;
                if (usr && !e[4]) ok = 0;
                if (!usr && e[4] && (!sum || acc == 0)) ok = 0;
                if (acc == 0 && !e[3]) ok = 0;
                if (acc == 1 && !(e[1] || (mxr && e[3]))) ok = 0;
                if (acc == 2 && !e[2]) ok = 0;
                if (lvl > 0 && ((e[53:10] % (longint'(1) << (9*lvl))) != 0)) ok = 0;
                if (!ok) begin f = 1; break; end
                begin
                    longint unsigned m = (longint'(1) << (12 + 9*lvl)) - 1;
                    pa = 56'(((longint'(e[53:10]) * 4096) & ~m) | (longint'(va) & m));
                end
                if (!e[6] || (acc == 2 && !e[7])) begin
                    q_addr.push_back(a); q_we.push_back(1);
                    q_data.push_back(e | 64'h40 | ((acc == 2) ? 64'h80 : 64'h0));
                end
                break;
            end
            if (lvl == 0) begin f = 1; break; end
            base = longint'(e[53:10]) * 4096;
            lvl--;
        end
        if (!f) c = 4'd0;
    endtask

    task automatic do_walk(input logic [38:0] va, input logic [1:0] acc, input bit usr,
                           input bit sum, input bit mxr, input string tag);
        bit ef; logic [3:0] ec; logic [55:0] epa;
        bit done = 0, rsp_pend = 0, mhold = 0, rhold = 0;
        logic [63:0] rsp_d = '0;
        logic [55:0] haddr = '0, hpa = '0;
        int cyc = 0;
        q_addr.delete(); q_we.delete(); q_data.delete();
        model(va, acc, usr, sum, mxr, ef, ec, epa);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "idle before request", 64'(req_ready), 64'd1);
        req_va = va; req_type = acc; req_user = usr; req_sum = sum; req_mxr = mxr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 400) begin
            mem_rsp_valid = rsp_pend;
            mem_rsp_data  = rsp_d;
            rsp_pend = 0;
            chk(req_ready == 1'b0, "R10", "busy blocks requests", 64'(req_ready), 64'd0);
            if (mem_req_valid) begin
                if (mhold) chk(mem_req_addr == haddr, "R11", "stalled address held", 64'(mem_req_addr), 64'(haddr));
                mem_req_ready = next_ready();
                if (mem_req_ready) begin
                    mhold = 0;
                    if (q_addr.size() == 0) begin
                        chk(0, tag, "unexpected memory access", 64'(mem_req_addr), 64'd0);
                    end else begin
                        chk(mem_req_addr == q_addr[0], tag, "entry address", 64'(mem_req_addr), 64'(q_addr[0]));
                        chk(mem_req_we == q_we[0], tag, "write flag", 64'(mem_req_we), 64'(q_we[0]));
                        if (q_we[0]) chk(mem_req_wdata == q_data[0], "R9", "written entry", mem_req_wdata, q_data[0]);
                        void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
                    end
                    if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
                    else begin rsp_pend = 1; rsp_d = rd(mem_req_addr); end
                end else begin
                    mhold = 1; haddr = mem_req_addr;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
            if (res_valid) begin
                if (rhold) chk(res_pa == hpa, "R10", "held result", 64'(res_pa), 64'(hpa));
                res_ready = next_ready();
                if (res_ready) begin
                    chk(res_fault == ef, tag, "fault flag", 64'(res_fault), 64'(ef));
                    if (ef) chk(res_cause == ec, tag, "fault cause", 64'(res_cause), 64'(ec));
                    else chk(res_pa == epa, tag, "physical address", 64'(res_pa), 64'(epa));
                    chk(q_addr.size() == 0, tag, "memory accesses missing", 64'(q_addr.size()), 64'd0);
                    done = 1;
                end else begin
                    rhold = 1; hpa = res_pa;
                end
            end else begin
                res_ready = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        mem_req_ready = 1'b0; res_ready = 1'b0; mem_rsp_valid = 1'b0;
        if (!done) chk(0, tag, "watchdog expired", 64'(cyc), 64'd0);
    endtask

    initial begin
        longint unsigned rb = longint'(ROOT) * 4096;
        longint unsigned t1 = 'h80001000, t0 = 'h80002000, t3 = 'h80003000;
        mem[56'(rb + 1*8)]  = mk('h80001, 10'h001);
        mem[56'(t1 + 2*8)]  = mk('h80002, 10'h001);
        mem[56'(t0 + 3*8)]  = mk('h12345, 10'h0C7);
        mem[56'(t0 + 4*8)]  = mk('h12346, 10'h007);
        mem[56'(t0 + 5*8)]  = mk('h12347, 10'h047);
        mem[56'(t0 + 6*8)]  = mk('h12348, 10'h0C7);
        mem[56'(t0 + 7*8)]  = mk('h12349, 10'h001);
        mem[56'(t0 + 8*8)]  = mk('h1234A, 10'h049);
        mem[56'(t0 + 9*8)]  = mk('h1234B, 10'h0DF);
        mem[56'(t0 + 10*8)] = mk('h1234C, 10'h003);
        mem[56'(rb + 2*8)]  = mk('h40000, 10'h0C7);
        mem[56'(rb + 3*8)]  = mk('h80003, 10'h001);
        mem[56'(t3 + 'h10*8)] = mk('h22200, 10'h0C3);
        mem[56'(t3 + 'h11*8)] = mk('h22201, 10'h0C3);
        mem[56'(rb + 5*8)]  = mk('h40001, 10'h0C7);

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
        chk(res_valid == 1'b0, "R1", "reset res_valid", 64'(res_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        do_walk(mkva(1, 2, 3, 'h123), 2'd1, 0, 0, 0, "R2");
        do_walk(mkva(1, 2, 4, 'h0AB), 2'd1, 0, 0, 0, "R9");
        stall_en = 1'b1;
        do_walk(mkva(1, 2, 4, 'h0AB), 2'd2, 0, 0, 0, "R9");
        do_walk(mkva(1, 2, 5, 'hFFF), 2'd2, 0, 0, 0, "R3");
        do_walk(mkva(1, 2, 6, 'h010), 2'd0, 0, 0, 0, "R6");
        do_walk(mkva(1, 2, 7, 'h020), 2'd1, 0, 0, 0, "R5");
        do_walk(mkva(1, 2, 8, 'h030), 2'd1, 0, 0, 1, "R6");
        do_walk(mkva(1, 2, 8, 'h030), 2'd1, 0, 0, 0, "R6");
        do_walk(mkva(1, 2, 9, 'h040), 2'd1, 1, 0, 0, "R6");
        do_walk(mkva(1, 2, 9, 'h040), 2'd1, 0, 0, 0, "R6");
        do_walk(mkva(1, 2, 9, 'h040), 2'd1, 0, 1, 0, "R6");
        do_walk(mkva(1, 2, 9, 'h040), 2'd0, 0, 1, 0, "R6");
        do_walk(mkva(1, 2, 3, 'h050), 2'd1, 1, 0, 0, "R6");
        do_walk(mkva(1, 2, 10, 'h060), 2'd2, 0, 0, 0, "R9");
        do_walk(mkva(2, 'h55, 'h1AA, 'hABC), 2'd1, 0, 0, 0, "R8");
        do_walk(mkva(2, 'h13, 'h0F0, 'h001), 2'd2, 0, 0, 0, "R8");
        do_walk(mkva(3, 'h10, 'h17F, 'h5A5), 2'd0, 0, 0, 0, "R8");
        do_walk(mkva(3, 'h11, 'h001, 'h000), 2'd1, 0, 0, 0, "R7");
        do_walk(mkva(5, 0, 0, 'h000), 2'd1, 0, 0, 0, "R7");
        do_walk(mkva(4, 0, 0, 'h100), 2'd2, 0, 0, 0, "R4");
        do_walk(mkva(4, 0, 0, 'h100), 2'd0, 0, 0, 0, "R4");
        do_walk(mkva(4, 0, 0, 'h100), 2'd1, 0, 0, 0, "R4");
        stall_en = 1'b0;
        do_walk(mkva(1, 2, 3, 'h7FE), 2'd2, 0, 0, 0, "R11");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 global watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule